// File: doc/BRIEF.md
# Fast Accumulator and Shadow Core Address Mapper

This block sits between a processor's address generation and its two storage targets: a small file of fast accumulators and the main core memory. Every access carries a virtual address. The block decides which target the access goes to and, for core accesses made in user mode, adds a relocation offset and checks the address against a protection limit. Each request is presented for one cycle. The routed strobe, index or physical address, and write data appear on registered outputs one clock later.

Whether an access goes to the accumulator file is decided from the virtual address, before any relocation. Virtual addresses below the accumulator count go to the accumulators while they are enabled. The core words at the same physical addresses form a shadow region. Software reaches that region in two ways. One is to run in bootstrap read-in mode, which switches the accumulators off until the program counter first moves past the accumulator window. The other is to use a user-mode virtual address whose relocated sum wraps past the top of the 18-bit space and lands in that window.

Top module: `acshadow_mapper`

## Requirements
- R1: After synchronous reset, ac_req, core_req and prot_fault are low, the accumulators are enabled, the relocation is 0 and the protection limit is 777777 octal.
- R2: A request with virtual address below 16 (0 to 17 octal) while the accumulators are enabled, and not faulted, asserts ac_req with ac_idx equal to the low 4 address bits and ac_wr equal to req_write, and does not assert core_req.
- R3: In exec mode (user_mode low), a request that does not go to the accumulators asserts core_req with core_addr equal to the virtual address, no relocation, and core_wr equal to req_write.
- R4: In the cycle in which readin_mode goes from low to high, the accumulators become disabled, and virtual addresses 0 to 17 octal go to core at the same physical address (shadow memory).
- R5: Once disabled, the accumulators stay disabled until a cycle in which pc exceeds 17 octal. The enable takes effect for the request in that same cycle and stays set when pc falls back, until readin_mode rises again.
- R6: In user mode, core_addr equals (virtual address + relocation) modulo 2^18.
- R7: The accumulator decision uses the virtual address. With relocation 36000 octal, user virtual address 742000 octal reaches core address 0 and not an accumulator, while user virtual address 5 reaches accumulator 5.
- R8: A pulse on rp_load loads the protection limit from rp_data[35:18] and the relocation from rp_data[17:0] in one write. The new values apply from the following cycle. A request in the load cycle uses the old values.
- R9: In user mode, a virtual address above the protection limit asserts prot_fault for one cycle and neither ac_req nor core_req. An address equal to the limit is allowed, and exec mode is never checked.
- R10: Outputs are registered with one cycle of latency. A cycle with req_valid low produces no strobe, and out_wdata carries the req_wdata of the previous cycle.
- R11: At most one of ac_req, core_req and prot_fault is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_vaddr | input | 18 | Virtual address of the access |
| req_wdata | input | 36 | Write data |
| user_mode | input | 1 | 1 = user mode (relocate and protect) |
| readin_mode | input | 1 | Bootstrap read-in mode level |
| pc | input | 18 | Current program counter |
| rp_load | input | 1 | Load limit and relocation |
| rp_data | input | 36 | [35:18] limit, [17:0] relocation |
| ac_req | output | 1 | Accumulator access strobe |
| ac_wr | output | 1 | Accumulator write |
| ac_idx | output | 4 | Accumulator index |
| core_req | output | 1 | Core access strobe |
| core_wr | output | 1 | Core write |
| core_addr | output | 18 | Physical core address |
| out_wdata | output | 36 | Registered write data |
| prot_fault | output | 1 | Protection violation pulse |

## Verification
The mapper is tried with exec-mode addresses on both sides of the 17/20 octal boundary, which separates accumulator hits from flat core accesses. Read-in entry, with pc held at 17 octal and then stepped to 20 octal, shows whether the enable follows the first pc excursion and not the mode level. User-mode addresses whose relocated sum wraps past 777777 octal show whether the accumulator test uses the virtual address or the physical one. Addresses at, just below and above the limit, together with a load issued in the same cycle as a request, pin down the protection comparison and the timing of the register update.

// File: rtl/acsm_pkg.sv
package acsm_pkg;
  typedef enum logic [1:0] {
    RT_NONE  = 2'd0,
    RT_AC    = 2'd1,
    RT_CORE  = 2'd2,
    RT_FAULT = 2'd3
  } route_e;
endpackage

// File: rtl/acsm_enable_ctrl.sv
module acsm_enable_ctrl #(
  parameter int ADDR_W   = 18,
  parameter int AC_COUNT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              readin_mode,
  input  logic [ADDR_W-1:0] pc,
  output logic              ac_en_now
);
  localparam logic [ADDR_W-1:0] AC_TOP = ADDR_W'(AC_COUNT - 1);

  logic readin_q;
  logic ac_en_q;
  logic entering;
  logic pc_past_window;

  assign entering       = readin_mode && !readin_q;
  assign pc_past_window = (pc > AC_TOP);
  // entry dominates; otherwise the flag is sticky once pc leaves the window
  assign ac_en_now      = entering ? 1'b0 : (ac_en_q || pc_past_window);

  always_ff @(posedge clk) begin
    if (rst) begin
      readin_q <= 1'b0;
      ac_en_q  <= 1'b1;
    end else begin
      readin_q <= readin_mode;
      ac_en_q  <= ac_en_now;
    end
  end
endmodule

// File: rtl/acsm_reloc_reg.sv
module acsm_reloc_reg #(
  parameter int ADDR_W = 18
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [2*ADDR_W-1:0] data,
  output logic [ADDR_W-1:0]   limit,
  output logic [ADDR_W-1:0]   reloc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      limit <= '1;
      reloc <= '0;
    end else if (load) begin
      limit <= data[2*ADDR_W-1:ADDR_W];
      reloc <= data[ADDR_W-1:0];
    end
  end
endmodule

// File: rtl/acsm_route.sv
module acsm_route #(
  parameter int ADDR_W   = 18,
  parameter int AC_COUNT = 16,
  parameter int IDX_W    = 4
) (
  input  logic                  req_valid,
  input  logic                  user_mode,
  input  logic                  ac_en,
  input  logic [ADDR_W-1:0]     vaddr,
  input  logic [ADDR_W-1:0]     limit,
  input  logic [ADDR_W-1:0]     reloc,
  output acsm_pkg::route_e      route,
  output logic [ADDR_W-1:0]     paddr
);
  import acsm_pkg::*;

  logic in_window;

  generate
    if ((AC_COUNT & (AC_COUNT - 1)) == 0) begin : g_pow2
      assign in_window = (vaddr[ADDR_W-1:IDX_W] == '0);
    end else begin : g_any
      assign in_window = (vaddr < ADDR_W'(AC_COUNT));
    end
  endgenerate

  // sum truncates to ADDR_W bits, giving the modulo wrap
  assign paddr = user_mode ? (vaddr + reloc) : vaddr;

  always_comb begin
    if (!req_valid)                      route = RT_NONE;
    else if (user_mode && vaddr > limit) route = RT_FAULT;
    else if (ac_en && in_window)         route = RT_AC;
    else                                 route = RT_CORE;
  end
endmodule

// File: rtl/acshadow_mapper.sv
module acshadow_mapper #(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 36,
  parameter int AC_COUNT = 16,
  parameter int IDX_W    = $clog2(AC_COUNT)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_vaddr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic                user_mode,
  input  logic                readin_mode,
  input  logic [ADDR_W-1:0]   pc,
  input  logic                rp_load,
  input  logic [2*ADDR_W-1:0] rp_data,
  output logic                ac_req,
  output logic                ac_wr,
  output logic [IDX_W-1:0]    ac_idx,
  output logic                core_req,
  output logic                core_wr,
  output logic [ADDR_W-1:0]   core_addr,
  output logic [DATA_W-1:0]   out_wdata,
  output logic                prot_fault
);
  import acsm_pkg::*;

  logic              ac_en_now;
  logic [ADDR_W-1:0] limit;
  logic [ADDR_W-1:0] reloc;
  logic [ADDR_W-1:0] paddr;
  route_e            route;

  acsm_enable_ctrl #(.ADDR_W(ADDR_W), .AC_COUNT(AC_COUNT)) u_en (
    .clk(clk), .rst(rst), .readin_mode(readin_mode), .pc(pc),
    .ac_en_now(ac_en_now)
  );

  acsm_reloc_reg #(.ADDR_W(ADDR_W)) u_rp (
    .clk(clk), .rst(rst), .load(rp_load), .data(rp_data),
    .limit(limit), .reloc(reloc)
  );

  acsm_route #(.ADDR_W(ADDR_W), .AC_COUNT(AC_COUNT), .IDX_W(IDX_W)) u_route (
    .req_valid(req_valid), .user_mode(user_mode), .ac_en(ac_en_now),
    .vaddr(req_vaddr), .limit(limit), .reloc(reloc),
    .route(route), .paddr(paddr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ac_req     <= 1'b0;
      ac_wr      <= 1'b0;
      ac_idx     <= '0;
      core_req   <= 1'b0;
      core_wr    <= 1'b0;
      core_addr  <= '0;
      out_wdata  <= '0;
      prot_fault <= 1'b0;
    end else begin
      ac_req     <= (route == RT_AC);
      ac_wr      <= (route == RT_AC) && req_write;
      ac_idx     <= req_vaddr[IDX_W-1:0];
      core_req   <= (route == RT_CORE);
      core_wr    <= (route == RT_CORE) && req_write;
      core_addr  <= paddr;
      out_wdata  <= req_wdata;
      prot_fault <= (route == RT_FAULT);
    end
  end
endmodule

// File: rtl/acshadow_mapper_chk.sv
module acshadow_mapper_chk #(
  parameter int ADDR_W   = 18,
  parameter int AC_COUNT = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic              user_mode,
  input logic              readin_mode,
  input logic              ac_req,
  input logic              ac_wr,
  input logic              core_req,
  input logic [ADDR_W-1:0] core_addr,
  input logic              prot_fault
);
  AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ac_req, core_req, prot_fault})); // R11

  AST_AC_WINDOW: assert property (@(posedge clk) disable iff (rst)
    ac_req |-> ($past(req_vaddr) < ADDR_W'(AC_COUNT))); // R2

  AST_AC_WRITE: assert property (@(posedge clk) disable iff (rst)
    ac_req |-> (ac_wr == $past(req_write))); // R2

  AST_EXEC_FLAT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !user_mode && req_vaddr >= ADDR_W'(AC_COUNT))
      |=> (core_req && core_addr == $past(req_vaddr))); // R3

  AST_READIN_SHADOW: assert property (@(posedge clk) disable iff (rst)
    ($rose(readin_mode) && req_valid && req_vaddr < ADDR_W'(AC_COUNT))
      |=> !ac_req); // R4

  AST_FAULT_USER: assert property (@(posedge clk) disable iff (rst)
    prot_fault |-> ($past(user_mode) && $past(req_valid))); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!ac_req && !core_req && !prot_fault)); // R10
endmodule

bind acshadow_mapper acshadow_mapper_chk #(.ADDR_W(ADDR_W), .AC_COUNT(AC_COUNT)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_vaddr(req_vaddr), .user_mode(user_mode), .readin_mode(readin_mode),
  .ac_req(ac_req), .ac_wr(ac_wr), .core_req(core_req),
  .core_addr(core_addr), .prot_fault(prot_fault)
);

// File: tb/acshadow_mapper_bench.sv
module acshadow_mapper_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write, user_mode, readin_mode, rp_load;
  logic [17:0] req_vaddr, pc;
  logic [35:0] req_wdata, rp_data;
  logic        ac_req, ac_wr, core_req, core_wr, prot_fault;
  logic [3:0]  ac_idx;
  logic [17:0] core_addr;
  logic [35:0] out_wdata;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  acshadow_mapper u_acshadow_mapper (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_vaddr(req_vaddr), .req_wdata(req_wdata), .user_mode(user_mode),
    .readin_mode(readin_mode), .pc(pc), .rp_load(rp_load), .rp_data(rp_data),
    .ac_req(ac_req), .ac_wr(ac_wr), .ac_idx(ac_idx), .core_req(core_req),
    .core_wr(core_wr), .core_addr(core_addr), .out_wdata(out_wdata),
    .prot_fault(prot_fault)
  );

  // behavioural reference model
  int  m_acen, m_rdq, m_lim, m_rel;
  bit  e_ac, e_core, e_flt, e_wr;
  int  e_idx, e_addr;
  longint e_wdata;
  always @(posedge clk) begin
    bit entry;
    bit en;
    if (rst) begin
      m_acen = 1; m_rdq = 0; m_lim = 262143; m_rel = 0;
      e_ac = 0; e_core = 0; e_flt = 0; e_wr = 0; e_idx = 0; e_addr = 0; e_wdata = 0;
    end else begin
      entry = readin_mode && (m_rdq == 0);
      en = entry ? 1'b0 : ((m_acen != 0) || (int'(pc) > 15));
      e_ac = 0; e_core = 0; e_flt = 0; e_wr = req_write;
      if (req_valid) begin
        if (user_mode && int'(req_vaddr) > m_lim) e_flt = 1;
        else if (en && int'(req_vaddr) < 16) begin
          e_ac = 1; e_idx = int'(req_vaddr) % 16;
        end else begin
          e_core = 1;
          e_addr = user_mode ? (int'(req_vaddr) + m_rel) % 262144 : int'(req_vaddr);
        end
      end
      e_wdata = longint'(req_wdata);
      m_acen = en ? 1 : 0;
      m_rdq = readin_mode ? 1 : 0;
      if (rp_load) begin
        m_lim = int'(rp_data[35:18]);
        m_rel = int'(rp_data[17:0]);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(ac_req == e_ac, "R2 ac_req vs model", ac_req, e_ac);
      chk(core_req == e_core, "R3 core_req vs model", core_req, e_core);
      chk(prot_fault == e_flt, "R9 prot_fault vs model", prot_fault, e_flt);
      chk(out_wdata == e_wdata[35:0], "R10 out_wdata vs model", out_wdata, e_wdata);
      chk((32'(ac_req) + 32'(core_req) + 32'(prot_fault)) <= 1, "R11 single route",
          {ac_req, core_req, prot_fault}, 0);
      if (e_ac) begin
        chk(32'(ac_idx) == e_idx, "R2 ac_idx vs model", ac_idx, e_idx);
        chk(ac_wr == e_wr, "R2 ac_wr vs model", ac_wr, e_wr);
      end
      if (e_core) begin
        chk(32'(core_addr) == e_addr, "R6 core_addr vs model", core_addr, e_addr);
        chk(core_wr == e_wr, "R3 core_wr vs model", core_wr, e_wr);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic go();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic req(input bit usr, input bit wr, input logic [17:0] va);
    req_valid = 1'b1; user_mode = usr; req_write = wr; req_vaddr = va;
    req_wdata = {18'(va), 18'h2A5A5};
    go();
  endtask

  initial begin
    rst = 1'b1; req_valid = 0; req_write = 0; req_vaddr = '0; req_wdata = '0;
    user_mode = 0; readin_mode = 0; pc = 18'o100; rp_load = 0; rp_data = '0;
    repeat (3) go();
    chk(!ac_req && !core_req && !prot_fault, "R1 reset strobes low",
        {ac_req, core_req, prot_fault}, 0);
    rst = 1'b0;

    req(0, 1, 18'o5);
    chk(ac_req && ac_idx == 4'd5 && ac_wr && !core_req, "R1 R2 exec acc hit", {ac_req, ac_idx}, 'h15);
    chk(out_wdata == {18'o5, 18'h2A5A5}, "R10 wdata forwarded", out_wdata, {18'o5, 18'h2A5A5});
    req(0, 0, 18'o17);
    chk(ac_req && ac_idx == 4'hF, "R2 last accumulator", ac_idx, 15);
    req(0, 0, 18'o20);
    chk(core_req && core_addr == 18'o20 && !ac_req, "R3 first core word", core_addr, 18'o20);
    req(0, 1, 18'o123456);
    chk(core_req && core_wr && core_addr == 18'o123456, "R3 exec flat", core_addr, 18'o123456);
    req_valid = 0; go();
    chk(!ac_req && !core_req && !prot_fault, "R10 idle quiet", {ac_req, core_req}, 0);

    // read-in entry
    readin_mode = 1; pc = 18'o0;
    req(0, 0, 18'o3);
    chk(core_req && core_addr == 18'o3 && !ac_req, "R4 shadow on entry", core_addr, 3);
    pc = 18'o17;
    req(0, 0, 18'o17);
    chk(core_req && !ac_req, "R5 pc at 17 still shadow", ac_req, 0);
    pc = 18'o20;
    req(0, 0, 18'o4);
    chk(ac_req && ac_idx == 4'd4, "R5 pc past window enables", ac_req, 1);
    pc = 18'o5;
    req(0, 0, 18'o4);
    chk(ac_req, "R5 enable sticky", ac_req, 1);
    readin_mode = 0; go();
    readin_mode = 1;
    req(0, 0, 18'o2);
    chk(core_req && core_addr == 18'o2, "R4 re-entry disables", core_addr, 2);
    readin_mode = 0;
    req(0, 0, 18'o2);
    chk(core_req, "R5 disabled after mode drops", core_req, 1);
    pc = 18'o100;
    req(0, 0, 18'o2);
    chk(ac_req, "R5 reenabled by pc", ac_req, 1);

    // relocation
    rp_load = 1; rp_data = {18'o777777, 18'o036000};
    req(1, 0, 18'o742000);
    rp_load = 0;
    chk(core_req && core_addr == 18'o742000, "R8 load applies next cycle", core_addr, 18'o742000);
    req(1, 0, 18'o742000);
    chk(core_req && core_addr == 18'o0 && !ac_req, "R7 wrap to shadow 0", core_addr, 0);
    req(1, 1, 18'o742005);
    chk(core_req && core_addr == 18'o5, "R7 wrap to shadow 5", core_addr, 5);
    req(1, 0, 18'o5);
    chk(ac_req && ac_idx == 4'd5, "R7 virtual acc hit", ac_idx, 5);
    req(1, 0, 18'o1000);
    chk(core_req && core_addr == 18'o37000, "R6 relocated", core_addr, 18'o37000);

    // protection
    rp_load = 1; rp_data = {18'o1777, 18'o200000};
    req_valid = 0; go();
    rp_load = 0;
    req(1, 1, 18'o2000);
    chk(prot_fault && !core_req && !ac_req, "R9 above limit faults", prot_fault, 1);
    req(1, 0, 18'o1777);
    chk(core_req && core_addr == 18'o201777 && !prot_fault, "R9 at limit allowed", core_addr, 18'o201777);
    req(0, 0, 18'o700000);
    chk(core_req && core_addr == 18'o700000 && !prot_fault, "R9 exec unchecked", core_addr, 18'o700000);
    req_valid = 0; go();
    chk(!prot_fault, "R9 fault is a pulse", prot_fault, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule